// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as seven packed-BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year that stands for 2000 to 2099. A one-cycle strobe from an external one-second prescaler moves the count forward by one second. Month lengths and leap years are handled inside the block. The hours byte can hold a 24-hour value, or a 12-hour value with an AM/PM flag, and each form counts correctly.

A host interface, such as a serial slave, reaches the seven bytes through a burst port. When a burst opens, the live count is copied into a shadow set. Reads during the burst come from that copy, and writes go into it. When the burst closes, only the bytes that were written are copied back into the live count. A tick that falls inside a burst keeps advancing the live count, so time is not lost, and it never tears the value the host is reading. Writing the seconds byte sends a one-cycle request that clears the external sub-second prescaler.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the byte at each address reads back as follows: address 0 (seconds) = 0x00, address 1 (minutes) = 0x00, address 2 (hours) = 0x00 in 24-hour mode, address 3 (weekday) = 0x01, address 4 (day of month) = 0x01, address 5 (month) = 0x01, address 6 (year) = 0x00.
- R2: Each tick_1hz pulse advances seconds in BCD. Seconds go from 0x59 to 0x00 and carry one minute, and minutes go from 0x59 to 0x00 and carry one hour. Without a tick or a commit, the count does not change.
- R3: When hours bit 6 is 0 (24-hour mode), hours count 0x00 to 0x23. The step from 0x23 to 0x00 advances the date by one day.
- R4: When hours bit 6 is 1 (12-hour mode), bits 4..0 count 12, 1, 2 … 11 in BCD and bit 5 marks PM. Bit 5 toggles on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM. Bit 6 is kept on every step.
- R5: Weekday counts 1 to 7 and returns from 7 to 1 each time the date advances.
- R6: Day of month returns to 0x01 after the last day of the month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and for month 2 either 29 (the year's value is divisible by 4) or 28 (otherwise). Month returns from 0x12 to 0x01 and carries one year, and the year goes from 0x99 to 0x00.
- R7: The cycle in which bus_active rises copies the live count into the shadow. While the burst stays open, bus_rdata shows shadow bytes only, so ticks during the burst are not visible to the host until the next burst.
- R8: The byte pointer loads from bus_addr when a burst opens. A bus_addr above 6 loads 0. The pointer steps by one on each bus_rd or bus_wr strobe and wraps from 6 to 0.
- R9: A bus_wr stores bus_wdata into the shadow byte at the pointer. The cycle in which bus_active falls copies only the written bytes into the live count, and the other bytes keep their live value. A commit takes priority over a tick in the same cycle.
- R10: presc_clr is high for exactly the one cycle after a commit that includes the seconds byte, and it stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_active | input | 1 | High for the length of a host burst |
| bus_addr | input | 3 | Start byte address, sampled when the burst opens |
| bus_wr | input | 1 | Write strobe: stores bus_wdata at the pointer, then steps the pointer |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe: steps the pointer after the current byte is taken |
| bus_rdata | output | 8 | Shadow byte at the current pointer |
| presc_clr | output | 1 | One-cycle request to clear the sub-second prescaler |

## Verification
Directed start times are placed just before each rollover. Among them are the end of a century, the end of February in leap and non-leap years, the ends of 30-day and 31-day months, and the 11→12 and 12→1 steps of 12-hour mode on both sides of noon and midnight. Each one shows whether one particular carry path or length rule is right. Seeded random start times, biased toward the end of a minute, hour or month and followed by random runs of ticks, are compared with a binary calendar model in the bench. This exposes carry chains that go wrong only after many steps, or only in one hour encoding. Further bursts check the ordering of host access against counting: ticks inside a read burst, partial writes that must leave the bytes not written still counting, a start address that wraps or is out of range, and whether the prescaler clear follows a write to seconds alone.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int NUM_REGS = 7;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int FLAT_W   = NUM_REGS * BYTE_W;
    localparam int SEC_IDX  = 0;
    localparam int HR_MODE_BIT = 6;
    localparam int HR_PM_BIT   = 5;

    // Field order puts seconds in the least significant byte: address i = byte i.
    typedef struct packed {
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] mday;
        logic [BYTE_W-1:0] wday;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 8'h00, mon: 8'h01, mday: 8'h01,
                                   wday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic is_leap(input logic [7:0] year_bcd);
        logic [7:0] b;
        b = bcd_to_bin(year_bcd);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] year);
        case (mon)
            8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input cal_t c, input logic [ADDR_W-1:0] idx);
        logic [FLAT_W-1:0] f;
        f = c;
        return f[idx*BYTE_W +: BYTE_W];
    endfunction

    function automatic cal_t put_byte(input cal_t c, input logic [ADDR_W-1:0] idx,
                                      input logic [BYTE_W-1:0] d);
        logic [FLAT_W-1:0] f;
        f = c;
        f[idx*BYTE_W +: BYTE_W] = d;
        return cal_t'(f);
    endfunction
endpackage

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic c_min, c_hour, c_day, c_mon;
    logic [4:0] h12_digits;
    logic       h12_pm;

    always_comb begin
        nxt        = cur;
        c_min      = 1'b0;
        c_hour     = 1'b0;
        c_day      = 1'b0;
        c_mon      = 1'b0;
        h12_digits = cur.hour[4:0];
        h12_pm     = cur.hour[HR_PM_BIT];

        // seconds and minutes
        if (cur.sec == 8'h59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end
        if (c_min) begin
            if (cur.min == 8'h59) begin
                nxt.min = 8'h00;
                c_hour  = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        // hours, in whichever encoding the mode bit selects
        if (c_hour) begin
            if (cur.hour[HR_MODE_BIT]) begin
                if (cur.hour[4:0] == 5'h11) begin
                    h12_digits = 5'h12;
                    h12_pm     = ~cur.hour[HR_PM_BIT];
                    c_day      = cur.hour[HR_PM_BIT];
                end else if (cur.hour[4:0] == 5'h12) begin
                    h12_digits = 5'h01;
                end else begin
                    h12_digits = bcd_inc({3'b000, cur.hour[4:0]}) [4:0];
                end
                nxt.hour = {1'b0, 1'b1, h12_pm, h12_digits};
            end else begin
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour = 8'h00;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = {2'b00, bcd_inc({2'b00, cur.hour[5:0]}) [5:0]};
                end
            end
        end

        // calendar
        if (c_day) begin
            nxt.wday = (cur.wday >= 8'h07) ? 8'h01 : cur.wday + 8'h01;
            if (cur.mday == month_len(cur.mon, cur.year)) begin
                nxt.mday = 8'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.mday = bcd_inc(cur.mday);
            end
        end
        if (c_mon) begin
            if (cur.mon == 8'h12) begin
                nxt.mon  = 8'h01;
                nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
            end else begin
                nxt.mon = bcd_inc(cur.mon);
            end
        end
    end
endmodule

// File: rtl/rtc_cal_host_port.sv
module rtc_cal_host_port
    import rtc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cal_t                live,
    input  logic                bus_active,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [BYTE_W-1:0]   bus_rdata,
    output cal_t                shadow,
    output logic [NUM_REGS-1:0] dirty,
    output logic [ADDR_W-1:0]   ptr,
    output logic                act_q,
    output logic                commit
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic              start;
    logic [ADDR_W-1:0] ptr_next;

    assign start     = bus_active & ~act_q;
    assign ptr_next  = (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
    assign commit    = act_q & ~bus_active & (|dirty);
    assign bus_rdata = get_byte(shadow, ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            shadow <= CAL_RESET;
            dirty  <= '0;
            ptr    <= '0;
        end else begin
            act_q <= bus_active;
            if (start) begin
                shadow <= live;
                dirty  <= '0;
                ptr    <= (bus_addr > LAST_ADDR) ? '0 : bus_addr;
            end else if (bus_active && bus_wr) begin
                shadow     <= put_byte(shadow, ptr, bus_wdata);
                dirty[ptr] <= 1'b1;
                ptr        <= ptr_next;
            end else if (bus_active && bus_rd) begin
                ptr <= ptr_next;
            end
        end
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_active,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              presc_clr
);
    cal_t                live_q;
    cal_t                live_next;
    cal_t                shadow;
    logic [NUM_REGS-1:0] dirty;
    logic [ADDR_W-1:0]   ptr;
    logic                act_q;
    logic                commit;
    logic [FLAT_W-1:0]   merged;
    logic [FLAT_W-1:0]   live_flat;
    logic [FLAT_W-1:0]   shadow_flat;

    rtc_cal_advance u_adv (
        .cur (live_q),
        .nxt (live_next)
    );

    rtc_cal_host_port u_host (
        .clk        (clk),
        .rst        (rst),
        .live       (live_q),
        .bus_active (bus_active),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .shadow     (shadow),
        .dirty      (dirty),
        .ptr        (ptr),
        .act_q      (act_q),
        .commit     (commit)
    );

    assign live_flat   = live_q;
    assign shadow_flat = shadow;

    // byte-wise merge of written shadow bytes over the live count
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_merge
        assign merged[i*BYTE_W +: BYTE_W] = dirty[i] ? shadow_flat[i*BYTE_W +: BYTE_W]
                                                     : live_flat[i*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= CAL_RESET;
            presc_clr <= 1'b0;
        end else begin
            presc_clr <= commit & dirty[SEC_IDX];
            if (commit)        live_q <= cal_t'(merged);
            else if (tick_1hz) live_q <= live_next;
        end
    end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              bus_active,
    input logic              bus_wr,
    input logic              act_q,
    input logic              commit,
    input logic              presc_clr,
    input logic [ADDR_W-1:0] ptr,
    input logic [FLAT_W-1:0] live,
    input logic [FLAT_W-1:0] shadow
);
    // R2: a tick with no commit always moves the seconds byte
    p_tick_moves_sec_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !commit) |=> !$stable(live[7:0]));

    // R2: no tick and no commit leaves the live count unchanged
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !commit) |=> $stable(live));

    // R4: counting never changes the 12/24-hour mode bit
    p_mode_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !commit) |=> $stable(live[2*BYTE_W + HR_MODE_BIT]));

    // R7: inside an open burst without writes the snapshot is frozen
    p_snapshot_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_active && act_q && !bus_wr) |=> $stable(shadow));

    // R8: the byte pointer stays within the seven registers
    p_ptr_range_r8: assert property (@(posedge clk) disable iff (rst)
        ptr <= ADDR_W'(NUM_REGS - 1));

    // R10: the prescaler clear only follows the close of a burst
    p_presc_after_end_r10: assert property (@(posedge clk) disable iff (rst)
        presc_clr |-> $past(act_q && !bus_active));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_1hz   (tick_1hz),
    .bus_active (bus_active),
    .bus_wr     (bus_wr),
    .act_q      (act_q),
    .commit     (commit),
    .presc_clr  (presc_clr),
    .ptr        (ptr),
    .live       (live_flat),
    .shadow     (shadow_flat)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       bus_active = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       presc_clr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // binary model of the calendar
    int m_sec, m_min, m_hr, m_wday, m_mday, m_mon, m_yr;
    bit m_12h;

    always #5 clk = ~clk;

    rtc_bcd_calendar u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_active(bus_active),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .presc_clr(presc_clr)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte(input bit h12, input int hr);
        int hh;
        if (!h12) return to_bcd(hr);
        hh = hr % 12;
        if (hh == 0) hh = 12;
        return 8'h40 | ((hr >= 12) ? 8'h20 : 8'h00) | to_bcd(hh);
    endfunction

    function automatic logic [7:0] exp_byte(input int idx);
        case (idx)
            0: return to_bcd(m_sec);
            1: return to_bcd(m_min);
            2: return hour_byte(m_12h, m_hr);
            3: return 8'(m_wday);
            4: return to_bcd(m_mday);
            5: return to_bcd(m_mon);
            default: return to_bcd(m_yr);
        endcase
    endfunction

    task automatic model_tick();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        m_mday++;
        if (m_mday <= days_in(m_mon, m_yr)) return;
        m_mday = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1;
        m_yr = (m_yr + 1) % 100;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_tick();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        @(negedge clk);
        model_tick();
    endtask

    task automatic bus_begin(input logic [2:0] a);
        bus_active = 1'b1;
        bus_addr   = a;
        @(negedge clk);
    endtask

    task automatic bus_end();
        bus_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(output logic [7:0] d);
        d = bus_rdata;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] d);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_time(input bit h12, input int yr, input int mon, input int md,
                            input int wd, input int hr, input int mi, input int se);
        m_12h = h12; m_yr = yr; m_mon = mon; m_mday = md;
        m_wday = wd; m_hr = hr; m_min = mi; m_sec = se;
        bus_begin(3'd0);
        for (int i = 0; i < 7; i++) bus_write(exp_byte(i));
        bus_end();
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        bus_begin(3'd0);
        for (int i = 0; i < 7; i++) begin
            bus_read(d);
            check(req, d, exp_byte(i));
        end
        bus_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240229));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset contents
        m_12h = 0; m_yr = 0; m_mon = 1; m_mday = 1; m_wday = 1; m_hr = 0; m_min = 0; m_sec = 0;
        check_all("R1 reset");
        check("R10 idle presc", {7'd0, presc_clr}, 8'h00);

        // R2 plain second and minute carries, R9 full write
        set_time(0, 24, 5, 10, 3, 10, 20, 58);
        check_all("R9 full write");
        do_tick(); check_all("R2 sec step");
        do_tick(); check_all("R2 minute carry");
        repeat (5) @(negedge clk);
        check_all("R2 hold without tick");

        // R3 R5 R6 end of century
        set_time(0, 99, 12, 31, 7, 23, 59, 59);
        do_tick(); check_all("R3 R5 R6 century wrap");
        // R6 leap and non-leap February, 30 and 31 day months
        set_time(0, 24, 2, 28, 2, 23, 59, 59);
        do_tick(); check_all("R6 leap feb 28");
        set_time(0, 24, 2, 29, 2, 23, 59, 59);
        do_tick(); check_all("R6 leap feb 29");
        set_time(0, 23, 2, 28, 2, 23, 59, 59);
        do_tick(); check_all("R6 common feb");
        set_time(0, 30, 4, 30, 4, 23, 59, 59);
        do_tick(); check_all("R6 april end");
        set_time(0, 30, 1, 31, 6, 23, 59, 59);
        do_tick(); check_all("R6 january end");

        // R4 12-hour mode steps
        set_time(1, 40, 6, 15, 2, 11, 59, 59);
        do_tick(); check_all("R4 11AM to 12PM");
        set_time(1, 40, 6, 15, 2, 12, 59, 59);
        do_tick(); check_all("R4 12PM to 1PM");
        set_time(1, 40, 6, 30, 2, 23, 59, 59);
        do_tick(); check_all("R4 11PM to 12AM day step");
        set_time(1, 40, 6, 15, 2, 0, 59, 59);
        do_tick(); check_all("R4 12AM to 1AM");

        // R7 ticks during a read burst are hidden from that burst
        set_time(0, 12, 3, 3, 3, 10, 20, 30);
        bus_begin(3'd0);
        for (int i = 0; i < 5; i++) begin
            tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0; @(negedge clk);
        end
        for (int i = 0; i < 7; i++) begin
            bus_read(d);
            check("R7 snapshot", d, exp_byte(i));
        end
        bus_end();
        repeat (5) model_tick();
        check_all("R7 live kept counting");

        // R8 start address, wrap and out-of-range start
        bus_begin(3'd5);
        bus_read(d); check("R8 start at 5", d, exp_byte(5));
        bus_read(d); check("R8 step to 6", d, exp_byte(6));
        bus_read(d); check("R8 wrap to 0", d, exp_byte(0));
        bus_end();
        bus_begin(3'd7);
        bus_read(d); check("R8 addr 7 maps to 0", d, exp_byte(0));
        bus_end();

        // R9 R10 partial write leaves seconds counting and no clear
        bus_begin(3'd1);
        bus_write(8'h45);
        do_tick();
        bus_active = 1'b0;
        @(negedge clk);
        m_min = 45;
        check("R10 no clear without seconds", {7'd0, presc_clr}, 8'h00);
        check_all("R9 partial write");

        // R10 writing seconds pulses the prescaler clear once
        bus_begin(3'd0);
        bus_write(8'h10);
        bus_active = 1'b0;
        @(negedge clk);
        m_sec = 10;
        check("R10 clear pulse", {7'd0, presc_clr}, 8'h01);
        @(negedge clk);
        check("R10 clear one cycle", {7'd0, presc_clr}, 8'h00);
        check_all("R9 seconds commit");

        // R9 commit takes priority over a tick in the same cycle
        bus_begin(3'd0);
        bus_write(8'h20);
        bus_active = 1'b0;
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        m_sec = 20;
        check_all("R9 commit over tick");

        // random start times near rollovers, random tick runs
        for (int it = 0; it < 30; it++) begin
            int yr, mon, md, hr, mi, se, n;
            bit h12;
            h12 = ($urandom % 3) == 0;
            yr  = $urandom % 100;
            mon = 1 + $urandom % 12;
            md  = ($urandom % 2) ? days_in(mon, yr) : 1 + $urandom % days_in(mon, yr);
            hr  = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : $urandom % 24;
            mi  = ($urandom % 2) ? 59 : $urandom % 60;
            se  = 40 + $urandom % 20;
            set_time(h12, yr, mon, md, 1 + $urandom % 7, hr, mi, se);
            n = 1 + $urandom % 150;
            for (int k = 0; k < n; k++) do_tick();
            check_all(h12 ? "R4 R6 random 12h" : "R3 R6 random 24h");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule